// File: doc/BRIEF.md
# Timer Channel Output Control

This block owns the output latches of a multi-channel timer and drives one output pin from each. Every channel takes a single-cycle event pulse from its counter. Each channel also has three configuration bits: an output mode, an active level and an output enable. In toggle mode, a channel's own event pulse inverts its latch. In set/reset mode, the channel pairs with the channel just below it, so channel n takes channel (n-1) mod NCH as its master. One event of the pair drives the latch to the active level and the other drives it back. This is how a master period counter and a slave duty counter form a PWM waveform.

Software reaches the block through a small register port. Latch writes are strobed per channel and take effect only while the channel's output is disabled. While the output is enabled, only event pulses move the latch. The mode, level and enable vectors sit in their own writable registers. Any register, including the latches, can be read through a combinational read mux.

Top module: `tmr_out_ctrl`

## Requirements
- R1: After an active-low reset, every latch, mode bit, level bit and enable bit reads 0 and every pin is low.
- R2: With enable 1 and mode 0, a channel's own event inverts its latch at the next clock edge. The level bit and the partner's event have no effect.
- R3: With enable 1, mode 1 and level 0, the partner event (channel (n-1) mod NCH) sets the latch to 1 and the channel's own event clears it to 0, at the next edge.
- R4: With enable 1, mode 1 and level 1, the roles swap: the partner event clears the latch and the own event sets it.
- R5: With enable 1 and mode 1, when own and partner events arrive in the same cycle, the own event wins. The latch takes the value of the level bit.
- R6: While a channel's enable bit is 1, a strobed software write to its latch leaves the latch unchanged.
- R7: While a channel's enable bit is 0, its events are ignored. A write strobe loads the matching write-data bit into the latch at the next edge.
- R8: The read port is combinational and valid at any time. rd_sel 0 returns mode, 1 returns level, 2 returns enable and 3 returns the latches.
- R9: A configuration write with cfg_sel 0, 1 or 2 replaces the mode, level or enable vector at the next edge. cfg_sel 3 changes nothing.
- R10: Each pin equals its latch and changes only at a clock edge, never combinationally from an event input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NCH | Per-channel event pulses |
| out_we_i | input | NCH | Per-channel latch write strobes |
| out_wdata_i | input | NCH | Latch write data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target: 0 mode, 1 level, 2 enable |
| cfg_wdata_i | input | NCH | Configuration write data |
| rd_sel_i | input | 2 | Read selector: 0 mode, 1 level, 2 enable, 3 latch |
| rd_data_o | output | NCH | Read data |
| tout_o | output | NCH | Channel output pins |

## Verification
On every cycle, the assertions check the per-channel latch transitions: toggle, partner set or clear, own-wins on a tie, blocked writes while enabled, and direct loads with events ignored while disabled. They also check configuration writes to the enable vector. Only the bench's scenarios show the reset state and readback through every read selector. The same holds for the absence of a combinational path from the events to the pins, and for the PWM-like sequences that chain set and clear across neighbouring channels in both polarities.

// File: rtl/tco_pkg.sv
package tco_pkg;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_LEVEL  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_LATCH  = 2'd3
    } tco_sel_e;

endpackage

// File: rtl/tco_lane.sv
// Next-value logic for one channel's output latch.
module tco_lane (
    input  logic mode,
    input  logic lvl,
    input  logic en,
    input  logic own_evt,
    input  logic par_evt,
    input  logic sw_we,
    input  logic sw_bit,
    input  logic cur,
    output logic nxt
);
    always_comb begin
        nxt = cur;
        if (!en) begin
            if (sw_we) nxt = sw_bit;
        end else if (!mode) begin
            if (own_evt) nxt = ~cur;
        end else begin
            // own event wins over the partner on a tie
            if (own_evt)      nxt = lvl;
            else if (par_evt) nxt = ~lvl;
        end
    end
endmodule

// File: rtl/tco_rdmux.sv
module tco_rdmux
    import tco_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] en,
    input  logic [W-1:0] lat,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (tco_sel_e'(sel))
            SEL_MODE:   dout = mode;
            SEL_LEVEL:  dout = lvl;
            SEL_ENABLE: dout = en;
            default:    dout = lat;
        endcase
    end
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl
    import tco_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic [NCH-1:0] out_we_i,
    input  logic [NCH-1:0] out_wdata_i,
    input  logic           cfg_we_i,
    input  logic [1:0]     cfg_sel_i,
    input  logic [NCH-1:0] cfg_wdata_i,
    input  logic [1:0]     rd_sel_i,
    output logic [NCH-1:0] rd_data_o,
    output logic [NCH-1:0] tout_o
);
    typedef struct packed {
        logic [NCH-1:0] mode;
        logic [NCH-1:0] lvl;
        logic [NCH-1:0] en;
        logic [NCH-1:0] lat;
    } st_t;

    st_t            st_d, st_q;
    logic [NCH-1:0] lat_nxt;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        localparam int PAR = (i == 0) ? NCH - 1 : i - 1;
        tco_lane u_lane (
            .mode    (st_q.mode[i]),
            .lvl     (st_q.lvl[i]),
            .en      (st_q.en[i]),
            .own_evt (evt_i[i]),
            .par_evt (evt_i[PAR]),
            .sw_we   (out_we_i[i]),
            .sw_bit  (out_wdata_i[i]),
            .cur     (st_q.lat[i]),
            .nxt     (lat_nxt[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.lat = lat_nxt;
        if (cfg_we_i) begin
            case (tco_sel_e'(cfg_sel_i))
                SEL_MODE:   st_d.mode = cfg_wdata_i;
                SEL_LEVEL:  st_d.lvl  = cfg_wdata_i;
                SEL_ENABLE: st_d.en   = cfg_wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tco_rdmux #(.W(NCH)) u_rdmux (
        .sel  (rd_sel_i),
        .mode (st_q.mode),
        .lvl  (st_q.lvl),
        .en   (st_q.en),
        .lat  (st_q.lat),
        .dout (rd_data_o)
    );

    assign tout_o = st_q.lat;
endmodule

// File: rtl/tco_chk.sv
module tco_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] evt_i,
    input logic [NCH-1:0] out_we_i,
    input logic [NCH-1:0] out_wdata_i,
    input logic           cfg_we_i,
    input logic [1:0]     cfg_sel_i,
    input logic [NCH-1:0] cfg_wdata_i,
    input logic [NCH-1:0] mode,
    input logic [NCH-1:0] lvl,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] tout_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int PAR = (i == 0) ? NCH - 1 : i - 1;

        a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            en[i] && !mode[i] && evt_i[i] |=> tout_o[i] != $past(tout_o[i]));

        a_r3_partner_sets: assert property (@(posedge clk) disable iff (!rst_n)
            en[i] && mode[i] && !lvl[i] && evt_i[PAR] && !evt_i[i] |=> tout_o[i]);

        a_r4_partner_clears: assert property (@(posedge clk) disable iff (!rst_n)
            en[i] && mode[i] && lvl[i] && evt_i[PAR] && !evt_i[i] |=> !tout_o[i]);

        a_r5_own_wins: assert property (@(posedge clk) disable iff (!rst_n)
            en[i] && mode[i] && evt_i[i] && evt_i[PAR] |=> tout_o[i] == $past(lvl[i]));

        a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            en[i] && !evt_i[i] && !(mode[i] && evt_i[PAR]) |=> $stable(tout_o[i]));

        a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] && out_we_i[i] |=> tout_o[i] == $past(out_wdata_i[i]));

        a_r7_events_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] && !out_we_i[i] |=> $stable(tout_o[i]));
    end

    a_r9_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && cfg_sel_i == 2'd2 |=> en == $past(cfg_wdata_i));

    a_r9_sel3_inert: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && cfg_sel_i == 2'd3 |=> $stable(mode) && $stable(lvl) && $stable(en));
endmodule

bind tmr_out_ctrl tco_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .out_we_i    (out_we_i),
    .out_wdata_i (out_wdata_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .mode        (st_q.mode),
    .lvl         (st_q.lvl),
    .en          (st_q.en),
    .tout_o      (tout_o)
);

// File: tb/tmr_out_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_out_ctrl_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0, owe = '0, owd = '0, cwd = '0;
    logic         cwe = 1'b0;
    logic [1:0]   csel = '0, rsel = 2'd3;
    logic [N-1:0] rdata, tout;

    logic [N-1:0] m_mode = '0, m_lvl = '0, m_en = '0, m_lat = '0;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_out_ctrl #(.NCH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .out_we_i(owe), .out_wdata_i(owd),
        .cfg_we_i(cwe), .cfg_sel_i(csel), .cfg_wdata_i(cwd),
        .rd_sel_i(rsel), .rd_data_o(rdata), .tout_o(tout)
    );

    function automatic logic lane_exp(logic md, logic lv, logic e, logic own, logic par,
                                      logic we, logic wb, logic cur);
        if (!e) return we ? wb : cur;
        if (!md) return own ? ~cur : cur;
        if (own) return lv;
        if (par) return ~lv;
        return cur;
    endfunction

    function automatic logic [N-1:0] rd_exp(logic [1:0] s);
        case (s)
            2'd0: return m_mode;
            2'd1: return m_lvl;
            2'd2: return m_en;
            default: return m_lat;
        endcase
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: update the model from the current inputs, then clear pulses
    task automatic cyc();
        logic [N-1:0] nl;
        for (int i = 0; i < N; i++) begin
            int p = (i == 0) ? N - 1 : i - 1;
            nl[i] = lane_exp(m_mode[i], m_lvl[i], m_en[i], evt[i], evt[p], owe[i], owd[i], m_lat[i]);
        end
        @(posedge clk);
        #1;
        if (rst_n) begin
            m_lat = nl;
            if (cwe) case (csel)
                2'd0: m_mode = cwd;
                2'd1: m_lvl  = cwd;
                2'd2: m_en   = cwd;
                default: ;
            endcase
        end
        evt = '0; owe = '0; cwe = 1'b0;
    endtask

    task automatic cfg(logic [1:0] s, logic [N-1:0] d);
        cwe = 1'b1; csel = s; cwd = d;
        cyc();
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(); cyc();
        rst_n = 1'b1;
        #1;
        // R1 reset state through every selector
        for (int s = 0; s < 4; s++) begin
            rsel = 2'(s); #1;
            chk("R1 reset readback", rdata, '0);
        end
        chk("R1 reset pins", tout, '0);

        // R9 configuration writes
        cfg(2'd0, 8'h0F); cfg(2'd1, 8'h05);
        rsel = 2'd0; #1; chk("R9 mode write", rdata, 8'h0F);
        rsel = 2'd1; #1; chk("R9 level write", rdata, 8'h05);
        cfg(2'd3, 8'hFF);
        rsel = 2'd0; #1; chk("R9 sel3 inert mode", rdata, 8'h0F);
        rsel = 2'd2; #1; chk("R9 sel3 inert enable", rdata, 8'h00);

        // R7 disabled: writes load, events ignored
        owe = 8'hFF; owd = 8'hA5; cyc();
        chk("R7 write loads", tout, 8'hA5);
        rsel = 2'd3; #1; chk("R8 latch readback", rdata, 8'hA5);
        evt = 8'hFF; cyc();
        chk("R7 events ignored", tout, 8'hA5);
        owe = 8'h0F; owd = 8'h00; cyc();
        chk("R7 partial strobe", tout, 8'hA0);
        owe = 8'hFF; owd = 8'h00; cyc();

        // R2 toggle mode, level ignored
        cfg(2'd0, 8'h00); cfg(2'd1, 8'hFF); cfg(2'd2, 8'hFF);
        rsel = 2'd2; #1; chk("R8 enable readback", rdata, 8'hFF);
        evt = 8'h01; cyc(); chk("R2 toggle up", tout, 8'h01);
        evt = 8'h01; cyc(); chk("R2 toggle down", tout, 8'h00);
        evt = 8'h81; cyc(); chk("R2 partner ignored", tout, 8'h81);

        // R6 writes blocked while enabled
        owe = 8'hFF; owd = 8'h7E; cyc();
        chk("R6 write blocked", tout, 8'h81);

        // back to zero, set/reset mode with level 0
        cfg(2'd2, 8'h00); owe = 8'hFF; owd = 8'h00; cyc();
        cfg(2'd0, 8'hFF); cfg(2'd1, 8'h00); cfg(2'd2, 8'hFF);
        evt = 8'h01; cyc(); chk("R3 partner sets", tout, 8'h02);
        // R10: event raised, pin holds until the edge
        evt = 8'h02; #3; chk("R10 no comb path", tout, 8'h02);
        cyc(); chk("R3 own clears", tout, 8'h04);

        // R4 swapped roles
        cfg(2'd1, 8'hFF);
        evt = 8'h01; cyc(); chk("R4 swapped", tout, 8'h05);

        // R5 tie: own wins, latch = level bit
        cfg(2'd1, 8'h02);
        evt = 8'h03; cyc(); chk("R5 tie level1", tout, 8'h06);
        cfg(2'd1, 8'h00);
        evt = 8'h03; cyc(); chk("R5 tie level0", tout, 8'h04);
        chk("R10 pins match latch", tout, m_lat);

        // random mix against the model
        for (int k = 0; k < 3000; k++) begin
            evt  = N'($urandom);
            owe  = N'($urandom);
            owd  = N'($urandom);
            cwe  = ($urandom % 8) == 0;
            csel = 2'($urandom);
            cwd  = N'($urandom);
            cyc();
            chk("R2 R3 R4 R5 R6 R7 random pins", tout, m_lat);
            rsel = 2'($urandom); #1;
            chk("R8 R9 random readback", rdata, rd_exp(rsel));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule